// File: doc/BRIEF.md
# Block Address Translation Unit

This unit translates a 32-bit effective address to a real address through four programmable block-mapping entries that serve one address space (instruction or data). Each entry is a pair of 32-bit words. An upper word describes the effective block base, the block size and the privilege levels for which the entry is live. A lower word gives the real block base and the access permission code. Software loads the words through a simple write port. The privilege level comes in on a mode input.

A request carries an effective address and an access kind. The unit checks the address against every entry that is live in the current privilege level. The lowest-numbered matching entry supplies the translation. The permission code of that entry decides whether the access kind is allowed. A denied access produces a protection fault in place of an address. When translation is switched off, the address passes through unchanged. Every result is registered and appears one cycle after the request.

Bit numbers below count from 0 at the least significant bit.

Top module: `bat_xlate_unit`

## Requirements
- R1: After reset the response outputs are all zero and every entry word is zero, so each entry is invalid and a translated request misses.
- R2: Upper word layout. Bits [31:17] hold the effective block base, bits [12:2] hold the 11-bit size field, bit 1 makes the entry live in supervisor mode (user_mode_i=0), and bit 0 makes it live in user mode (user_mode_i=1).
- R3: Lower word layout. Bits [31:17] hold the real block base and bits [1:0] hold the permission code. On a hit, ra_o is the effective address bits inside the block offset mask ORed with the real block base.
- R4: An entry takes part in matching only if its live bit for the current privilege mode is set.
- R5: The offset mask is the size field placed at bits [27:17] ORed with 0x1FFFF. Blocks are therefore 128 KB times a power of two. A hit needs the effective address with the offset-mask bits cleared to equal the effective block base.
- R6: When several live entries match, the lowest-numbered one supplies both the translation and the permission code.
- R7: The access kind is encoded as 0 = data read, 1 = data write, 2 = instruction fetch. Permission code 0 denies every access. Codes 1 and 3 allow read and fetch but deny write. Code 2 allows every access.
- R8: A denied access on a hit gives hit_o=1, fault_o=1, fault_code_o=1 (protection) and ra_o=0xFFFFFFFF. In every other case fault_o=0 and fault_code_o=0.
- R9: With xlate_en_i=0, a request returns ra_o equal to ea_i, with hit_o=0 and no fault, whatever the entries hold.
- R10: rsp_valid_o follows req_valid_i with one cycle of delay. A cycle without a request leaves hit_o, fault_o, fault_code_o and ra_o at zero in the next cycle.
- R11: A write sets the upper word (wr_hi_i=1) or the lower word (wr_hi_i=0) of entry wr_sel_i. A lookup in the same cycle as the write still sees the old word, and the new word applies from the next cycle.
- R12: A translated request that matches no live entry gives hit_o=0, fault_o=0 and ra_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry word write strobe |
| wr_sel_i | input | 2 | Entry number to write |
| wr_hi_i | input | 1 | 1 writes the upper word, 0 writes the lower word |
| wr_data_i | input | 32 | Write data |
| user_mode_i | input | 1 | 1 = user privilege, 0 = supervisor |
| xlate_en_i | input | 1 | Translation enable |
| req_valid_i | input | 1 | Lookup request |
| ea_i | input | 32 | Effective address |
| acc_i | input | 2 | Access kind |
| rsp_valid_o | output | 1 | Response valid |
| hit_o | output | 1 | A live entry matched |
| fault_o | output | 1 | Protection fault |
| fault_code_o | output | 2 | Fault reason, 1 = protection |
| ra_o | output | 32 | Real address |

## Verification
The assertions check, on every cycle, the properties that do not depend on entry contents. These are the one-cycle response timing, the zero outputs when there is no request, the pass-through with translation off, and the shape of a faulted response (all-ones address, protection code, hit set). Checks that need the entry contents can only come from the bench's scenarios. These are the field decoding, the block-size boundaries, the privilege filter, the lowest-index priority between overlapping blocks, the permission matrix, and write-versus-lookup ordering. The bench covers each of these against its reference model.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int AW     = 32;
  localparam int OFS_W  = 17;               // minimum block offset width
  localparam int BL_W   = 11;               // size field width
  localparam int BL_LSB = 2;
  localparam int SV_BIT = 1;
  localparam int UV_BIT = 0;
  localparam int PP_W   = 2;
  localparam int PAD_W  = AW - BL_W - OFS_W;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_IF = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_PROT = 2'd1
  } fcode_e;
endpackage

// File: rtl/bat_regfile.sv
module bat_regfile import bat_pkg::*; #(
  parameter int N_ENT = 4,
  localparam int SEL_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [SEL_W-1:0]          wr_sel_i,
  input  logic                      wr_hi_i,
  input  logic [AW-1:0]             wr_data_i,
  output logic [N_ENT-1:0][AW-1:0]  upper_o,
  output logic [N_ENT-1:0][AW-1:0]  lower_o
);
  logic [N_ENT-1:0][AW-1:0] upper_q, lower_q;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        upper_q[g] <= '0;
        lower_q[g] <= '0;
      end else if (wr_en_i && (wr_sel_i == SEL_W'(g))) begin
        if (wr_hi_i) upper_q[g] <= wr_data_i;
        else         lower_q[g] <= wr_data_i;
      end
    end
  end

  assign upper_o = upper_q;
  assign lower_o = lower_q;
endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match import bat_pkg::*; (
  input  logic [AW-1:0]   upper_i,
  input  logic [AW-1:0]   lower_i,
  input  logic [AW-1:0]   ea_i,
  input  logic            user_mode_i,
  output logic            match_o,
  output logic [AW-1:0]   ra_o,
  output logic [PP_W-1:0] pp_o
);
  logic [AW-1:0] ofs_mask, ea_base, rb_base;
  logic          live;

  always_comb begin
    ofs_mask = {{PAD_W{1'b0}}, upper_i[BL_LSB+BL_W-1:BL_LSB], {OFS_W{1'b1}}};
    ea_base  = {upper_i[AW-1:OFS_W], {OFS_W{1'b0}}};
    rb_base  = {lower_i[AW-1:OFS_W], {OFS_W{1'b0}}};
    live     = user_mode_i ? upper_i[UV_BIT] : upper_i[SV_BIT];
    match_o  = live && ((ea_i & ~ofs_mask) == ea_base);
    ra_o     = (ea_i & ofs_mask) | rb_base;
    pp_o     = lower_i[PP_W-1:0];
  end

  logic unused_bits;
  assign unused_bits = ^{upper_i[OFS_W-1:BL_LSB+BL_W], lower_i[OFS_W-1:PP_W]};
endmodule

// File: rtl/bat_prio_sel.sv
module bat_prio_sel import bat_pkg::*; #(
  parameter int N_ENT = 4
) (
  input  logic [N_ENT-1:0]            match_i,
  input  logic [N_ENT-1:0][AW-1:0]    ra_i,
  input  logic [N_ENT-1:0][PP_W-1:0]  pp_i,
  output logic                        hit_o,
  output logic [AW-1:0]               ra_o,
  output logic [PP_W-1:0]             pp_o
);
  // scan downward so the lowest matching index is the last to override
  always_comb begin
    hit_o = 1'b0;
    ra_o  = '0;
    pp_o  = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        hit_o = 1'b1;
        ra_o  = ra_i[i];
        pp_o  = pp_i[i];
      end
    end
  end
endmodule

// File: rtl/bat_prot_chk.sv
module bat_prot_chk import bat_pkg::*; (
  input  logic [PP_W-1:0] pp_i,
  input  logic [1:0]      acc_i,
  output logic            allow_o
);
  always_comb begin
    unique case (pp_i)
      2'b00:   allow_o = 1'b0;
      2'b10:   allow_o = 1'b1;
      default: allow_o = (acc_i != ACC_WR);
    endcase
  end
endmodule

// File: rtl/bat_xlate_unit.sv
module bat_xlate_unit import bat_pkg::*; #(
  parameter int N_ENT = 4,
  localparam int SEL_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic             wr_hi_i,
  input  logic [AW-1:0]    wr_data_i,
  input  logic             user_mode_i,
  input  logic             xlate_en_i,
  input  logic             req_valid_i,
  input  logic [AW-1:0]    ea_i,
  input  logic [1:0]       acc_i,
  output logic             rsp_valid_o,
  output logic             hit_o,
  output logic             fault_o,
  output logic [1:0]       fault_code_o,
  output logic [AW-1:0]    ra_o
);
  logic [N_ENT-1:0][AW-1:0]   upper, lower, ent_ra;
  logic [N_ENT-1:0][PP_W-1:0] ent_pp;
  logic [N_ENT-1:0]           ent_match;
  logic                       sel_hit, allow;
  logic [AW-1:0]              sel_ra;
  logic [PP_W-1:0]            sel_pp;

  bat_regfile #(.N_ENT(N_ENT)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_hi_i, .wr_data_i,
    .upper_o(upper), .lower_o(lower)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_match
    bat_entry_match u_match (
      .upper_i(upper[g]), .lower_i(lower[g]), .ea_i,
      .user_mode_i, .match_o(ent_match[g]), .ra_o(ent_ra[g]), .pp_o(ent_pp[g])
    );
  end

  bat_prio_sel #(.N_ENT(N_ENT)) u_sel (
    .match_i(ent_match), .ra_i(ent_ra), .pp_i(ent_pp),
    .hit_o(sel_hit), .ra_o(sel_ra), .pp_o(sel_pp)
  );

  bat_prot_chk u_prot (.pp_i(sel_pp), .acc_i, .allow_o(allow));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      hit_o        <= 1'b0;
      fault_o      <= 1'b0;
      fault_code_o <= FC_NONE;
      ra_o         <= '0;
    end else begin
      rsp_valid_o  <= req_valid_i;
      hit_o        <= 1'b0;
      fault_o      <= 1'b0;
      fault_code_o <= FC_NONE;
      ra_o         <= '0;
      if (req_valid_i) begin
        if (!xlate_en_i) begin
          ra_o <= ea_i;
        end else if (sel_hit) begin
          hit_o <= 1'b1;
          if (!allow) begin
            fault_o      <= 1'b1;
            fault_code_o <= FC_PROT;
            ra_o         <= '1;
          end else begin
            ra_o <= sel_ra;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bat_xlate_unit_chk.sv
module bat_xlate_unit_chk import bat_pkg::*; (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          xlate_en_i,
  input logic          req_valid_i,
  input logic [AW-1:0] ea_i,
  input logic          rsp_valid_o,
  input logic          hit_o,
  input logic          fault_o,
  input logic [1:0]    fault_code_o,
  input logic [AW-1:0] ra_o
);
  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !hit_o && !fault_o && ra_o == '0 && fault_code_o == 2'd0));

  a_r9_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !xlate_en_i) |=> (ra_o == $past(ea_i) && !hit_o && !fault_o));

  a_r8_fault_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (hit_o && rsp_valid_o && ra_o == '1 && fault_code_o == 2'd1));

  a_r8_code_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (fault_code_o == 2'd0));
endmodule

bind bat_xlate_unit bat_xlate_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .xlate_en_i(xlate_en_i),
  .req_valid_i(req_valid_i), .ea_i(ea_i), .rsp_valid_o(rsp_valid_o),
  .hit_o(hit_o), .fault_o(fault_o), .fault_code_o(fault_code_o), .ra_o(ra_o)
);

// File: tb/bat_xlate_unit_tb.sv
module bat_xlate_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_hi = 1'b0, user_mode = 1'b0, xlate_en = 1'b0, req = 1'b0;
  logic [1:0]  wr_sel = '0, acc = '0;
  logic [31:0] wr_data = '0, ea = '0;
  logic        rsp_valid, hit, fault;
  logic [1:0]  fcode;
  logic [31:0] ra;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit [31:0] m_up [4];
  bit [31:0] m_lo [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  bat_xlate_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_hi_i(wr_hi), .wr_data_i(wr_data), .user_mode_i(user_mode),
    .xlate_en_i(xlate_en), .req_valid_i(req), .ea_i(ea), .acc_i(acc),
    .rsp_valid_o(rsp_valid), .hit_o(hit), .fault_o(fault),
    .fault_code_o(fcode), .ra_o(ra)
  );

  function automatic bit [31:0] mk_up(bit [31:0] base, int unsigned bl, bit sv, bit uv);
    return (base & 32'hFFFE_0000) | ((bl & 11'h7FF) << 2) | (32'(sv) << 1) | 32'(uv);
  endfunction

  function automatic bit [31:0] mk_lo(bit [31:0] base, int unsigned pp);
    return (base & 32'hFFFE_0000) | (pp & 3);
  endfunction

  // behavioural reference: returns {valid, hit, fault, code[1:0], ra[31:0]}
  function automatic bit [36:0] model(bit v, bit en, bit um, bit [31:0] a, bit [1:0] k);
    longint unsigned blk_bytes, lo_addr, hi_addr, base;
    int unsigned pp;
    bit ok;
    if (!v)  return '0;
    if (!en) return {1'b1, 1'b0, 1'b0, 2'd0, a};
    for (int i = 0; i < 4; i++) begin
      if (!(um ? m_up[i][0] : m_up[i][1])) continue;
      blk_bytes = 64'd131072 << $countones(m_up[i][12:2]);
      base      = longint'(m_up[i] & 32'hFFFE_0000);
      if ((m_up[i][12:2] & (m_up[i][12:2] + 11'd1)) != 0) begin
        // non-contiguous size field: fall back to bitwise mask rule
        bit [31:0] msk = {4'd0, m_up[i][12:2], 17'h1FFFF};
        if ((a & ~msk) != base[31:0]) continue;
        lo_addr = longint'(a & msk);
      end else begin
        lo_addr = longint'(a) - base;
        hi_addr = longint'(a);
        if (hi_addr < base || lo_addr >= blk_bytes) continue;
      end
      pp = m_lo[i][1:0];
      case (pp)
        0: ok = 0;
        2: ok = 1;
        default: ok = (k != 2'd1);
      endcase
      if (!ok) return {1'b1, 1'b1, 1'b1, 2'd1, 32'hFFFF_FFFF};
      return {1'b1, 1'b1, 1'b0, 2'd0, 32'(lo_addr) | (m_lo[i] & 32'hFFFE_0000)};
    end
    return {1'b1, 1'b0, 1'b0, 2'd0, 32'd0};
  endfunction

  task automatic tick(input string tag);
    bit [36:0] e;
    e = model(req, xlate_en, user_mode, ea, acc);
    if (wr_en) begin
      if (wr_hi) m_up[wr_sel] = wr_data;
      else       m_lo[wr_sel] = wr_data;
    end
    @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if ({rsp_valid, hit, fault, fcode, ra} !== e) begin
      n_bad++;
      $display("FAIL %s: got v=%0b h=%0b f=%0b c=%0d ra=%08h exp v=%0b h=%0b f=%0b c=%0d ra=%08h",
               tag, rsp_valid, hit, fault, fcode, ra, e[36], e[35], e[34], e[33:32], e[31:0]);
    end
  endtask

  task automatic wr(input int sel, input bit hi, input bit [31:0] d, input string tag);
    wr_en = 1; wr_sel = 2'(sel); wr_hi = hi; wr_data = d;
    tick(tag);
    wr_en = 0;
  endtask

  task automatic look(input bit um, input bit [31:0] a, input bit [1:0] k, input string tag);
    req = 1; xlate_en = 1; user_mode = um; ea = a; acc = k;
    tick(tag);
    req = 0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_bad++;
        $display("FAIL watchdog: got cycles=%0d exp below %0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if ({rsp_valid, hit, fault, fcode, ra} !== '0) begin
      n_bad++;
      $display("FAIL R1 reset: got %0h exp 0", {rsp_valid, hit, fault, fcode, ra});
    end
    rst_n = 1;
    @(negedge clk);

    look(0, 32'h1001_2345, 2'd0, "R1 empty miss");
    look(1, 32'h0000_0000, 2'd2, "R12 miss user");

    // R11: lookup during the write sees the old (empty) entry
    wr(0, 0, mk_lo(32'h8000_0000, 2), "R11 lower write");
    req = 1; xlate_en = 1; user_mode = 0; ea = 32'h1001_2345; acc = 2'd0;
    wr(0, 1, mk_up(32'h1000_0000, 0, 1, 0), "R11 same-cycle old value");
    look(0, 32'h1001_2345, 2'd0, "R11 next-cycle new value R3");
    look(0, 32'h1002_0000, 2'd0, "R5 128K boundary miss");
    look(0, 32'h1001_FFFF, 2'd1, "R5 128K last byte write");
    look(1, 32'h1001_2345, 2'd0, "R4 user blocked");

    wr(1, 0, mk_lo(32'h4000_0000, 1), "R11 e1 lo");
    wr(1, 1, mk_up(32'h2000_0000, 7, 1, 1), "R2 e1 up");
    look(1, 32'h200F_FFFC, 2'd0, "R5 1M read user R4");
    look(1, 32'h2010_0000, 2'd0, "R5 1M boundary miss");
    look(1, 32'h2000_0040, 2'd1, "R8 write fault");
    look(1, 32'h2000_0040, 2'd2, "R7 fetch ok pp1");

    wr(2, 0, mk_lo(32'h6000_0000, 2), "R11 e2 lo");
    wr(2, 1, mk_up(32'h2000_0000, 11'h7FF, 1, 0), "R2 e2 up");
    look(0, 32'h2000_1000, 2'd0, "R6 lowest wins");
    look(0, 32'h2000_1000, 2'd1, "R6 lowest fault wins");
    look(0, 32'h2800_0000, 2'd1, "R6 second entry 256M");
    look(1, 32'h2800_0000, 2'd0, "R4 e2 not user");
    wr(1, 1, mk_up(32'h2000_0000, 7, 0, 0), "R4 disable e1");
    look(0, 32'h2000_1000, 2'd1, "R6 falls to e2");

    wr(3, 1, mk_up(32'h3000_0000, 0, 1, 1), "R2 e3 up");
    for (int p = 0; p < 4; p++) begin
      wr(3, 0, mk_lo(32'hA000_0000, p), "R3 e3 lo");
      for (int k = 0; k < 3; k++)
        look(p[0], 32'h3000_0ABC, 2'(k), "R7 matrix");
    end

    req = 1; xlate_en = 0; ea = 32'hDEAD_BEEC; acc = 2'd1;
    tick("R9 passthrough");
    ea = 32'h3000_0ABC; acc = 2'd0;
    tick("R9 passthrough over entry");
    req = 0; xlate_en = 1;
    tick("R10 idle");
    ea = 32'h1001_0000;
    tick("R10 idle no request");
    req = 1;
    for (int i = 0; i < 8; i++) begin
      ea = 32'h1000_0000 + 32'(i) * 32'h0000_8001;
      user_mode = i[0];
      acc = 2'(i % 3);
      tick("R10 back-to-back");
    end
    req = 0;
    tick("R10 drain");
    finish_run();
  end
endmodule